// File: doc/BRIEF.md
# Address-Keyed Block Pad Encryptor

This block encrypts or decrypts one 32-byte protected data block that lives off chip. The block is treated as two 16-byte halves. Each half is XORed with its own 128-bit pad. A pad is the output of a keyed 128-bit block cipher, and the cipher's input is built from the half's byte address and the block's 32-bit version (sequence) number. Because the same pad is used in both directions, one pass encrypts plaintext and a second pass with the same address and sequence number restores it.

The cipher is not part of this block. It sits behind a start/done handshake port, and the key comes from a hardware parameter on a dedicated output. The cipher is not pipelined, so the two pads are produced one after the other. The low half is always computed first and is released as soon as its pad arrives, so a consumer can use the low half while the high half's pad is still being computed. Both pads stay in output registers after the operation, so a later write-back can reuse them.

Top module: `blkpad_xor`

## Requirements
- R1: After reset, `data_out`, `pad_lo` and `pad_hi` are zero, and `half_ready`, `done`, `busy` and `ciph_start` are low.
- R2: Each cipher request carries the word {half address[127:96], sequence number[95:64], PAD_CONST[63:0]}. The low half uses `blk_addr` and the high half uses `blk_addr + 16`, which wraps modulo 2^32.
- R3: `ciph_key` always equals the KEY parameter.
- R4: The first cipher request of an operation is for the low half. The request for the high half is issued on the same edge that sets `half_ready[0]`, and `half_ready[1]` is never high while `half_ready[0]` is low.
- R5: On the edge that samples `ciph_done` for the low half, `pad_lo` takes `ciph_out`, `data_out[127:0]` becomes `data_in[127:0] ^ ciph_out`, and `half_ready[0]` is set.
- R6: On the edge that samples `ciph_done` for the high half, `pad_hi` and `data_out[255:128]` update in the same way. `half_ready[1]` is set, `done` pulses for one cycle and `busy` falls.
- R7: Running the block on its own result, with the same address and sequence number, returns the original data.
- R8: A `start` that arrives while `busy` is high is ignored. The operation in progress keeps its address, sequence number and data, and no extra cipher request is made.
- R9: While idle and without `start`, `pad_lo`, `pad_hi` and `data_out` hold their values, whatever the data inputs do.
- R10: An accepted `start` raises `busy` and clears `half_ready` on the next edge. Every `ciph_start` is a single-cycle pulse, and exactly two requests are made per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| blk_addr | input | 32 | Byte address of the block (address of the low half) |
| seq_num | input | 32 | Version number of the block |
| data_in | input | 256 | Block to transform; the low half is bits [127:0] |
| data_out | output | 256 | Transformed block |
| half_ready | output | 2 | Per-half result valid; bit 0 is the low half |
| done | output | 1 | One-cycle pulse when both halves are complete |
| busy | output | 1 | Operation in progress |
| pad_lo | output | 128 | Held pad of the low half |
| pad_hi | output | 128 | Held pad of the high half |
| ciph_start | output | 1 | Cipher request pulse |
| ciph_key | output | 128 | Fixed cipher key |
| ciph_in | output | 128 | Cipher input word |
| ciph_done | input | 1 | Cipher result strobe |
| ciph_out | input | 128 | Cipher result |

## Verification
The pad-and-XOR path is tried with four kinds of input:
- A patterned block at an ordinary address. This shows whether each half is paired with the right pad.
- An all-zero block. Here the output must equal the pads exactly, which exposes any masking or swapping of halves.
- A block at 0xFFFFFFF0 with the maximum sequence number. This separates correct 32-bit wrap of the high-half address from a widened or mis-offset sum.
- A second pass over the block's own result. This confirms that decryption reproduces the original data.

Two further runs cover control behaviour. One injects a `start` with different data in the middle of an operation. The other changes the inputs while the block is idle. Together they separate correct latching from a design that follows its inputs live.

// File: rtl/blkpad_xor.sv
`timescale 1ns/1ps
module blkpad_xor #(
  parameter logic [127:0] KEY        = 128'h2B7E_1516_28AE_D2A6_ABF7_1588_09CF_4F3C,
  parameter logic [63:0]  PAD_CONST  = 64'hA5C3_5A3C_0FF0_9669,
  parameter int           HALF_BYTES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [31:0]  blk_addr,
  input  logic [31:0]  seq_num,
  input  logic [255:0] data_in,
  output logic [255:0] data_out,
  output logic [1:0]   half_ready,
  output logic         done,
  output logic         busy,
  output logic [127:0] pad_lo,
  output logic [127:0] pad_hi,
  output logic         ciph_start,
  output logic [127:0] ciph_key,
  output logic [127:0] ciph_in,
  input  logic         ciph_done,
  input  logic [127:0] ciph_out
);
  localparam logic [31:0] HALF_OFS = 32'(HALF_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_WAIT0, S_WAIT1} st_t;
  st_t          st;
  logic [31:0]  addr_q, seq_q;
  logic [255:0] din_q;

  function automatic logic [127:0] spad(input logic [31:0] a, input logic [31:0] s);
    return {a, s, PAD_CONST};
  endfunction

  assign busy     = (st != S_IDLE);
  assign ciph_key = KEY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      seq_q      <= '0;
      din_q      <= '0;
      data_out   <= '0;
      pad_lo     <= '0;
      pad_hi     <= '0;
      half_ready <= '0;
      done       <= 1'b0;
      ciph_start <= 1'b0;
      ciph_in    <= '0;
    end else begin
      ciph_start <= 1'b0;
      done       <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q     <= blk_addr;
          seq_q      <= seq_num;
          din_q      <= data_in;
          half_ready <= 2'b00;
          ciph_in    <= spad(blk_addr, seq_num);
          ciph_start <= 1'b1;
          st         <= S_WAIT0;
        end
        S_WAIT0: if (ciph_done) begin
          pad_lo          <= ciph_out;
          data_out[127:0] <= din_q[127:0] ^ ciph_out;
          half_ready[0]   <= 1'b1;
          ciph_in         <= spad(addr_q + HALF_OFS, seq_q);
          ciph_start      <= 1'b1;
          st              <= S_WAIT1;
        end
        S_WAIT1: if (ciph_done) begin
          pad_hi            <= ciph_out;
          data_out[255:128] <= din_q[255:128] ^ ciph_out;
          half_ready[1]     <= 1'b1;
          done              <= 1'b1;
          st                <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ciph_start |=> !ciph_start); // R10
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ciph_start |-> busy); // R10
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && half_ready == 2'b00)); // R10
  AST_READY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    half_ready[1] |-> half_ready[0]); // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (half_ready == 2'b11 && !busy)); // R6
  AST_CIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ciph_done) |=> $stable(ciph_in)); // R8
  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pad_lo) && $stable(pad_hi) && $stable(data_out))); // R9
endmodule

// File: tb/tb_blkpad_xor.sv
`timescale 1ns/1ps
module tb_blkpad_xor;
  localparam logic [127:0] TKEY   = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  localparam logic [63:0]  TCONST = 64'h1357_9BDF_2468_ACE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] blk_addr = '0, seq_num = '0;
  logic [255:0] data_in = '0, data_out;
  logic [1:0] half_ready;
  logic done, busy, ciph_start, ciph_done;
  logic [127:0] pad_lo, pad_hi, ciph_key, ciph_in, ciph_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  blkpad_xor #(.KEY(TKEY), .PAD_CONST(TCONST), .HALF_BYTES(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr), .seq_num(seq_num),
    .data_in(data_in), .data_out(data_out), .half_ready(half_ready), .done(done),
    .busy(busy), .pad_lo(pad_lo), .pad_hi(pad_hi), .ciph_start(ciph_start),
    .ciph_key(ciph_key), .ciph_in(ciph_in), .ciph_done(ciph_done), .ciph_out(ciph_out));

  function automatic logic [127:0] fcipher(input logic [127:0] x, input logic [127:0] k);
    return {x[95:0], x[127:96]} ^ k ^ {4{x[31:0] ^ 32'h9E37_79B9}};
  endfunction

  // Stand-in cipher: 15-cycle latency, one result strobe per request
  int cnt = 0;
  int req_cnt = 0;
  logic [127:0] hold_in = '0, req_prev = '0, req_last = '0;
  always @(posedge clk) begin
    ciph_done <= 1'b0;
    if (ciph_start) begin
      hold_in  <= ciph_in;
      cnt      <= 15;
      req_cnt  <= req_cnt + 1;
      req_prev <= req_last;
      req_last <= ciph_in;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        ciph_done <= 1'b1;
        ciph_out  <= fcipher(hold_in, ciph_key);
      end
    end
  end
  initial ciph_out = '0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] xpad(input logic [31:0] a, input logic [31:0] s);
    return fcipher({a, s, TCONST}, TKEY);
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] s, input logic [255:0] d,
                        input bit inject, output logic [255:0] res);
    logic [127:0] p0, p1;
    bit seen0;
    int r0;
    p0 = xpad(a, s);
    p1 = xpad(a + 32'd16, s);
    seen0 = 0;
    r0 = req_cnt;
    @(negedge clk);
    blk_addr = a; seq_num = s; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && half_ready == 2'b00, "R10 busy after accept", {254'd0, busy, half_ready[0]}, 256'd2);
    for (int i = 0; i < 200; i++) begin
      if (inject && i == 5) begin
        blk_addr = ~a; seq_num = s + 32'd7; data_in = ~d; start = 1'b1;
      end else begin
        start = 1'b0;
        data_in = ~d;
      end
      if (half_ready[0] && !seen0) begin
        seen0 = 1;
        chk(half_ready[1] == 1'b0, "R4 low half first", {254'd0, half_ready}, 256'd1);
        chk(data_out[127:0] == (d[127:0] ^ p0), "R5 low half result", {128'd0, data_out[127:0]}, {128'd0, d[127:0] ^ p0});
        chk(pad_lo == p0, "R5 pad_lo", {128'd0, pad_lo}, {128'd0, p0});
      end
      if (done) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && half_ready == 2'b11 && !busy, "R6 done/busy", {253'd0, done, half_ready[1], busy}, 256'd6);
    chk(data_out == {d[255:128] ^ p1, d[127:0] ^ p0}, "R6 full result", data_out, {d[255:128] ^ p1, d[127:0] ^ p0});
    chk(pad_hi == p1, "R6 pad_hi", {128'd0, pad_hi}, {128'd0, p1});
    chk(req_prev == {a, s, TCONST}, "R2 low-half cipher input", {128'd0, req_prev}, {128'd0, a, s, TCONST});
    chk(req_last == {a + 32'd16, s, TCONST}, "R2 high-half cipher input", {128'd0, req_last}, {128'd0, a + 32'd16, s, TCONST});
    chk(req_cnt - r0 == 2, "R10 two requests", 256'(req_cnt - r0), 256'd2);
    @(negedge clk);
    chk(!done, "R6 done single pulse", {255'd0, done}, 256'd0);
    res = data_out;
  endtask

  task automatic t_reset();
    chk(data_out == '0 && pad_lo == '0 && pad_hi == '0, "R1 reset data", data_out | {pad_lo, pad_hi}, 256'd0);
    chk(half_ready == 0 && !done && !busy && !ciph_start, "R1 reset flags",
        {252'd0, half_ready, done, busy}, 256'd0);
    chk(ciph_key == TKEY, "R3 key port", {128'd0, ciph_key}, {128'd0, TKEY});
  endtask

  task automatic t_basic();
    logic [255:0] r;
    run_op(32'h0000_1000, 32'd1, {8{32'hDEAD_BEEF}} ^ {16{16'h0102}}, 0, r);
  endtask

  task automatic t_zero();
    logic [255:0] r;
    run_op(32'h0000_2040, 32'd5, '0, 0, r);
    chk(r == {xpad(32'h2050, 5), xpad(32'h2040, 5)}, "R5 zero data gives pads", r,
        {xpad(32'h2050, 5), xpad(32'h2040, 5)});
  endtask

  task automatic t_wrap();
    logic [255:0] r;
    run_op(32'hFFFF_FFF0, 32'hFFFF_FFFF, {4{64'h0123_4567_89AB_CDEF}}, 0, r);
    chk(req_last[127:96] == 32'h0, "R2 address wrap", {224'd0, req_last[127:96]}, 256'd0);
  endtask

  task automatic t_roundtrip();
    logic [255:0] pt, ct, back;
    pt = {64'hCAFE_F00D_1234_5678, 64'h0, 64'hFFFF_0000_FFFF_0000, 64'h8000_0000_0000_0001};
    run_op(32'h0000_3000, 32'd42, pt, 0, ct);
    run_op(32'h0000_3000, 32'd42, ct, 0, back);
    chk(back == pt, "R7 decrypt restores data", back, pt);
    chk(ct != pt, "R7 ciphertext differs", ct, ~pt);
  endtask

  task automatic t_busy_ignore();
    logic [255:0] r;
    run_op(32'h0000_4020, 32'd9, {32{8'h3C}}, 1, r);
    chk(r == {{16{8'h3C}} ^ xpad(32'h4030, 9), {16{8'h3C}} ^ xpad(32'h4020, 9)},
        "R8 busy start ignored", r, {{16{8'h3C}} ^ xpad(32'h4030, 9), {16{8'h3C}} ^ xpad(32'h4020, 9)});
  endtask

  task automatic t_hold();
    logic [255:0] r;
    logic [127:0] l, h;
    run_op(32'h0000_5000, 32'd3, {8{32'h1111_2222}}, 0, r);
    l = pad_lo; h = pad_hi;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      data_in = {8{32'(i * 977)}}; blk_addr = 32'(i); seq_num = 32'(i + 100);
    end
    @(negedge clk);
    chk(pad_lo == l && pad_hi == h, "R9 pads held", {pad_hi, pad_lo}, {h, l});
    chk(data_out == r && !busy, "R9 result held", data_out, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_zero();
    t_wrap();
    t_roundtrip();
    t_busy_ignore();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule